// File: doc/BRIEF.md
# Status word register with interruption gating

This block holds a 64-bit processor status word in the basic-control layout. It also works out which pending interruption requests the word currently allows. Bit 0 of the layout is the most significant bit, so layout bit k sits at vector index 63-k. Requests arrive from I/O channels, external events, machine checks and four program-exception classes. The block reports which of them are enabled, and which single one would be taken under a fixed priority.

There are two ways to change the word. A plain load replaces it. A swap is used when an interruption is taken. During the swap cycle, the old word appears on an output with the cause code inserted, and the length code too when asked. The new word is captured at the same clock edge.

The lower six channels each have their own mask bit in the word. The higher channels need two things at once: the summary I/O bit of the word, and their own bit in a separate channel-enable register that software can write. The block also drives the run/wait indication, the supervisor/problem state, a privileged-operation fault, the condition code and the next-instruction address.

Top module: `stword_gate`

## Requirements
- R1: After reset the word holds all zeros, so `run`=1, `problem`=0, `cc`=0, `ia`=0 and `spec_err`=0. The channel-enable register resets to all ones.
- R2: For channels 0 to 5, `en_io[n]` equals `pend_io[n]` AND word bit 63-n (layout bits 0 to 5).
- R3: For a channel n of 6 or above, `en_io[n]` equals `pend_io[n]` AND word bit 57 (layout bit 6, the summary) AND channel-enable register bit n-6. If bit 57 is zero, no channel from 6 upward is enabled.
- R4: `en_ext` is `pend_ext` AND word bit 56 (layout bit 7). `en_mchk` is `pend_mchk` AND word bit 50 (layout bit 13).
- R5: `en_prog[i]` is `pend_prog[i]` AND word bit 27-i. Index 0 is fixed-point overflow, 1 is decimal overflow, 2 is exponent underflow and 3 is significance.
- R6: A load captures its word at the next edge, with bits 47:30 (cause code and length code) forced to zero.
- R7: `old_word` shows the current word with `swp_cause` placed in bits 47:32. When `swp_len_en` is 1, `swp_len` also goes into bits 31:30. A swap captures `swp_new` (bits 47:30 cleared) at the same edge, and a swap wins over a load in the same cycle.
- R8: `run` is the inverse of word bit 49 (wait). `problem` is word bit 48. `priv_fault` is `priv_try` AND bit 48.
- R9: `spec_err` follows bit 51 (format) of the most recently captured word. It is 1 when that word's format bit was set, and a later capture with the bit clear returns it to 0.
- R10: `take_kind` encodes 0 = none, 1 = machine check, 2 = program, 3 = external and 4 = I/O. The priority is machine check, then program, then external, then I/O. `take_idx` is the lowest enabled program class or channel, and 0 for the other kinds. `take_valid` is 1 exactly when the kind is not 0.
- R11: `cc` is word bits 29:28 and `ia` is word bits 23:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Replace the word |
| ld_word | input | 64 | Word to load |
| swp_valid | input | 1 | Interruption swap |
| swp_new | input | 64 | New word for the swap |
| swp_cause | input | 16 | Cause code inserted into the old word |
| swp_len | input | 2 | Instruction length code |
| swp_len_en | input | 1 | Insert the length code |
| cr2_we | input | 1 | Write the channel-enable register |
| cr2_wdata | input | NCH-6 | Enables for channels 6 and up |
| pend_io | input | NCH | Pending channel requests |
| pend_ext | input | 1 | Pending external request |
| pend_mchk | input | 1 | Pending machine check |
| pend_prog | input | 4 | Pending program exceptions |
| priv_try | input | 1 | Privileged instruction attempted |
| en_io | output | NCH | Enabled channel requests |
| en_ext | output | 1 | External request enabled |
| en_mchk | output | 1 | Machine check enabled |
| en_prog | output | 4 | Program exceptions enabled |
| take_valid | output | 1 | Some interruption is takeable |
| take_kind | output | 3 | Winning class |
| take_idx | output | clog2(NCH) | Winning class index or channel |
| run | output | 1 | Instructions may issue |
| problem | output | 1 | Problem state |
| priv_fault | output | 1 | Privileged-operation fault |
| cc | output | 2 | Condition code |
| ia | output | 24 | Next-instruction address |
| spec_err | output | 1 | Last captured word had the format bit set |
| old_word | output | 64 | Word stored by a swap this cycle |

## Verification
A wrong word register or a wrong mask path shows up as a wrong enable bit. It appears combinationally in the first cycle after the capture, before any request is served, so the sweeps read it one cycle after each load. A wrong channel-enable register affects only channels 6 and up, and only while the summary bit is set. The sweep therefore crosses the summary bit with several register patterns.

A capture that fails to zero the cause and length fields is invisible until the next swap. It is read through `old_word` at once, with insertion disabled. A load that wrongly wins over a swap shows in `ia` one edge later.

// File: rtl/stword_pkg.sv
`timescale 1ns/1ps
package stword_pkg;
   localparam int WORD_W  = 64;
   localparam int LOW_CH  = 6;    // channels with a private mask bit
   localparam int NPROG   = 4;
   // vector indices (layout bit k lives at 63-k)
   localparam int B_IOSUM = 57;
   localparam int B_EXT   = 56;
   localparam int B_FMT   = 51;
   localparam int B_MCHK  = 50;
   localparam int B_WAIT  = 49;
   localparam int B_PROB  = 48;
   localparam int B_PMHI  = 27;
   localparam int IA_W    = 24;
   // cause code and length code are dropped on capture
   localparam logic [WORD_W-1:0] CAP_KEEP = ~64'h0000_FFFF_C000_0000;

   typedef enum logic [2:0] {
      TK_NONE = 3'd0,
      TK_MCHK = 3'd1,
      TK_PROG = 3'd2,
      TK_EXT  = 3'd3,
      TK_IO   = 3'd4
   } take_e;
endpackage

// File: rtl/stword_en.sv
`timescale 1ns/1ps
module stword_en import stword_pkg::*; #(
   parameter int NCH = 16,
   localparam int NHI = NCH - LOW_CH
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word,
   input  logic [NHI-1:0]    cr2,
   input  logic [NCH-1:0]    pend_io,
   input  logic              pend_ext,
   input  logic              pend_mchk,
   input  logic [NPROG-1:0]  pend_prog,
   output logic [NCH-1:0]    en_io,
   output logic              en_ext,
   output logic              en_mchk,
   output logic [NPROG-1:0]  en_prog
);
   for (genvar n = 0; n < NCH; n++) begin : g_ch
      if (n < LOW_CH) begin : g_low
         assign en_io[n] = pend_io[n] & word[WORD_W-1-n];
      end else begin : g_high
         assign en_io[n] = pend_io[n] & word[B_IOSUM] & cr2[n-LOW_CH];
      end
   end

   for (genvar i = 0; i < NPROG; i++) begin : g_pm
      assign en_prog[i] = pend_prog[i] & word[B_PMHI-i];
   end

   assign en_ext  = pend_ext  & word[B_EXT];
   assign en_mchk = pend_mchk & word[B_MCHK];

   // R3
   hi_chan_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !word[B_IOSUM] |-> (en_io[NCH-1:LOW_CH] == '0));
   // R2
   en_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_io & ~pend_io) == '0) && ((en_prog & ~pend_prog) == '0));
endmodule

// File: rtl/stword_pick.sv
`timescale 1ns/1ps
module stword_pick import stword_pkg::*; #(
   parameter int NCH = 16,
   localparam int CHW = $clog2(NCH)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCH-1:0]   en_io,
   input  logic             en_ext,
   input  logic             en_mchk,
   input  logic [NPROG-1:0] en_prog,
   output logic             take_valid,
   output logic [2:0]       take_kind,
   output logic [CHW-1:0]   take_idx
);
   take_e            kind;
   logic [CHW-1:0]   io_idx;
   logic [CHW-1:0]   pg_idx;

   always_comb begin
      io_idx = '0;
      for (int n = NCH-1; n >= 0; n--)
         if (en_io[n]) io_idx = CHW'(n);
      pg_idx = '0;
      for (int i = NPROG-1; i >= 0; i--)
         if (en_prog[i]) pg_idx = CHW'(i);
   end

   always_comb begin
      kind     = TK_NONE;
      take_idx = '0;
      if (en_mchk) begin
         kind = TK_MCHK;
      end else if (|en_prog) begin
         kind     = TK_PROG;
         take_idx = pg_idx;
      end else if (en_ext) begin
         kind = TK_EXT;
      end else if (|en_io) begin
         kind     = TK_IO;
         take_idx = io_idx;
      end
   end

   assign take_kind  = kind;
   assign take_valid = (kind != TK_NONE);

   // R10
   mchk_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_mchk |-> (take_kind == TK_MCHK));
   // R10
   io_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_kind == TK_IO) |-> (!en_ext && !en_mchk && en_prog == '0 && en_io[take_idx]));
endmodule

// File: rtl/stword_gate.sv
`timescale 1ns/1ps
module stword_gate import stword_pkg::*; #(
   parameter int                NCH        = 16,
   parameter logic [WORD_W-1:0] RESET_WORD = '0,
   localparam int               NHI        = NCH - LOW_CH,
   localparam int               CHW        = $clog2(NCH)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   input  logic [WORD_W-1:0] ld_word,
   input  logic              swp_valid,
   input  logic [WORD_W-1:0] swp_new,
   input  logic [15:0]       swp_cause,
   input  logic [1:0]        swp_len,
   input  logic              swp_len_en,
   input  logic              cr2_we,
   input  logic [NHI-1:0]    cr2_wdata,
   input  logic [NCH-1:0]    pend_io,
   input  logic              pend_ext,
   input  logic              pend_mchk,
   input  logic [NPROG-1:0]  pend_prog,
   input  logic              priv_try,
   output logic [NCH-1:0]    en_io,
   output logic              en_ext,
   output logic              en_mchk,
   output logic [NPROG-1:0]  en_prog,
   output logic              take_valid,
   output logic [2:0]        take_kind,
   output logic [CHW-1:0]    take_idx,
   output logic              run,
   output logic              problem,
   output logic              priv_fault,
   output logic [1:0]        cc,
   output logic [IA_W-1:0]   ia,
   output logic              spec_err,
   output logic [WORD_W-1:0] old_word
);
   if (NCH <= LOW_CH || NCH > 32) begin : g_bad_nch
      $error("stword_gate: NCH must lie in 7..32");
   end
   if (RESET_WORD[B_FMT] != 1'b0) begin : g_bad_reset
      $error("stword_gate: reset word must use the basic format");
   end

   logic [WORD_W-1:0] word_q;
   logic [NHI-1:0]    cr2_q;
   logic              spec_q;
   logic              cap;
   logic [WORD_W-1:0] cap_word;

   assign cap      = swp_valid | ld_valid;
   assign cap_word = swp_valid ? swp_new : ld_word;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= RESET_WORD & CAP_KEEP;
         cr2_q  <= '1;
         spec_q <= 1'b0;
      end else begin
         if (cap) begin
            word_q <= cap_word & CAP_KEEP;
            spec_q <= cap_word[B_FMT];
         end
         if (cr2_we) cr2_q <= cr2_wdata;
      end
   end

   assign old_word = {word_q[63:48], swp_cause,
                      (swp_len_en ? swp_len : word_q[31:30]), word_q[29:0]};

   stword_en #(.NCH(NCH)) u_en (
      .clk(clk), .rst_n(rst_n), .word(word_q), .cr2(cr2_q),
      .pend_io(pend_io), .pend_ext(pend_ext), .pend_mchk(pend_mchk),
      .pend_prog(pend_prog), .en_io(en_io), .en_ext(en_ext),
      .en_mchk(en_mchk), .en_prog(en_prog)
   );

   stword_pick #(.NCH(NCH)) u_pick (
      .clk(clk), .rst_n(rst_n), .en_io(en_io), .en_ext(en_ext),
      .en_mchk(en_mchk), .en_prog(en_prog), .take_valid(take_valid),
      .take_kind(take_kind), .take_idx(take_idx)
   );

   assign run        = ~word_q[B_WAIT];
   assign problem    = word_q[B_PROB];
   assign priv_fault = priv_try & word_q[B_PROB];
   assign cc         = word_q[29:28];
   assign ia         = word_q[IA_W-1:0];
   assign spec_err   = spec_q;

   // R6
   load_ia_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && !swp_valid) |=> (ia == $past(ld_word[IA_W-1:0])));
   // R7
   swap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      swp_valid |=> (ia == $past(swp_new[IA_W-1:0])));
   // R6
   len_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> (swp_len_en || old_word[31:30] == 2'b00));
   // R9
   spec_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> (spec_err == $past(cap_word[B_FMT])));
   // R11
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> ($stable(ia) && $stable(cc)));
endmodule

// File: tb/tb_stword_gate.sv
`timescale 1ns/1ps
module tb_stword_gate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_valid = 0, swp_valid = 0, swp_len_en = 0, cr2_we = 0;
   logic [63:0] ld_word = '0, swp_new = '0;
   logic [15:0] swp_cause = '0;
   logic [1:0]  swp_len = '0;
   logic [9:0]  cr2_wdata = '0;
   logic [15:0] pend_io = '0;
   logic        pend_ext = 0, pend_mchk = 0, priv_try = 0;
   logic [3:0]  pend_prog = '0;
   logic [15:0] en_io;
   logic        en_ext, en_mchk, take_valid, run, problem, priv_fault, spec_err;
   logic [3:0]  en_prog, take_idx;
   logic [2:0]  take_kind;
   logic [1:0]  cc;
   logic [23:0] ia;
   logic [63:0] old_word;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   always #10 clk = ~clk;

   stword_gate dut (.*);

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] pb(input int k);
      return 64'h1 << (63 - k);
   endfunction

   task automatic load(input logic [63:0] w);
      @(negedge clk); ld_valid = 1; ld_word = w;
      @(negedge clk); ld_valid = 0;
   endtask

   task automatic wr_cr2(input logic [9:0] v);
      @(negedge clk); cr2_we = 1; cr2_wdata = v;
      @(negedge clk); cr2_we = 0;
   endtask

   function automatic logic [15:0] exp_io(input int m, input int c, input int p);
      logic [15:0] e;
      for (int n = 0; n < 16; n++) begin
         int on;
         if (n < 6) on = (m >> (7 - n)) & 1;
         else       on = ((m >> 1) & 1) & ((c >> (n - 6)) & 1);
         e[n] = ((p >> n) & 1) & on;
      end
      return e;
   endfunction

   initial begin
      #(20 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int cr2s[4] = '{10'h3FF, 10'h155, 10'h2AA, 10'h000};
      int pends[3] = '{16'hFFFF, 16'h5555, 16'hAAAA};
      int iopat[6] = '{16'h0000, 16'h8000, 16'h0040, 16'h0021, 16'hFFFF, 16'h0300};
      logic [63:0] w1, w2, base;

      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk); #1;
      // R1 reset state
      chk(run == 1 && problem == 0 && cc == 0 && ia == 0 && spec_err == 0, "R1",
          {run, problem, cc, ia, spec_err}, 64'h2000_0000 >> 0 & 0 | {1'b1, 29'h0});
      chk(old_word == 64'h0, "R1", old_word, 64'h0);
      chk(take_valid == 0, "R1", take_valid, 0);
      // R1 channel-enable register resets to ones
      load(pb(6));
      pend_io = 16'hFFC0; #1;
      chk(en_io == 16'hFFC0, "R1", en_io, 16'hFFC0);
      pend_io = '0;

      // R2 R3 sweep over mask byte and channel-enable patterns
      for (int m = 0; m < 256; m++) begin
         load(64'(m) << 56);
         for (int c = 0; c < 4; c++) begin
            wr_cr2(cr2s[c][9:0]);
            for (int p = 0; p < 3; p++) begin
               pend_io = pends[p][15:0]; #1;
               chk(en_io == exp_io(m, cr2s[c], pends[p]), (m & 2) ? "R3" : "R2",
                   en_io, exp_io(m, cr2s[c], pends[p]));
            end
            pend_io = '0;
         end
         // R4 external
         pend_ext = 1; #1;
         chk(en_ext == m[0], "R4", en_ext, m[0]);
         pend_ext = 0;
      end
      wr_cr2(10'h3FF);

      // R4 machine check
      for (int b = 0; b < 2; b++) begin
         load(b ? pb(13) : 64'h0);
         for (int q = 0; q < 2; q++) begin
            pend_mchk = q[0]; #1;
            chk(en_mchk == (b[0] & q[0]), "R4", en_mchk, b[0] & q[0]);
         end
         pend_mchk = 0;
      end

      // R5 program mask
      for (int pm = 0; pm < 16; pm++) begin
         load(64'(pm) << 24);
         for (int pp = 0; pp < 16; pp++) begin
            logic [3:0] e;
            for (int i = 0; i < 4; i++) e[i] = pp[i] & pm[3 - i];
            pend_prog = pp[3:0]; #1;
            chk(en_prog == e, "R5", en_prog, e);
         end
         pend_prog = '0;
      end

      // R10 priority
      load(64'hFF00_0000_0000_0000 | pb(13) | (64'hF << 24));
      for (int mc = 0; mc < 2; mc++)
         for (int ex = 0; ex < 2; ex++)
            for (int pg = 0; pg < 16; pg++)
               for (int io = 0; io < 6; io++) begin
                  logic [7:0] e;
                  int lo;
                  if (mc) e = {1'b1, 3'd1, 4'd0};
                  else if (pg != 0) begin
                     lo = 0; while (!pg[lo]) lo++;
                     e = {1'b1, 3'd2, 4'(lo)};
                  end else if (ex) e = {1'b1, 3'd3, 4'd0};
                  else if (iopat[io] != 0) begin
                     lo = 0; while (!iopat[io][lo]) lo++;
                     e = {1'b1, 3'd4, 4'(lo)};
                  end else e = 8'h0;
                  pend_mchk = mc[0]; pend_ext = ex[0]; pend_prog = pg[3:0];
                  pend_io = iopat[io][15:0]; #1;
                  chk({take_valid, take_kind, take_idx} == e, "R10",
                      {take_valid, take_kind, take_idx}, e);
               end
      pend_mchk = 0; pend_ext = 0; pend_prog = '0; pend_io = '0;

      // R6 ignored fields on load
      w1 = 64'h1234_ABCD_FFFF_FFFF;
      load(w1);
      #1;
      chk(old_word == (w1 & ~64'h0000_FFFF_C000_0000), "R6", old_word,
          w1 & ~64'h0000_FFFF_C000_0000);
      // R7 swap with length insert, load in same cycle loses
      w2 = 64'h0F00_0000_0012_3456;
      @(negedge clk);
      swp_valid = 1; swp_new = w2; swp_cause = 16'hBEEF; swp_len = 2'b10; swp_len_en = 1;
      ld_valid = 1; ld_word = 64'h0000_0000_00FF_FFFF; #1;
      base = (w1 & ~64'h0000_FFFF_C000_0000) | (64'hBEEF << 32) | (64'h2 << 30);
      chk(old_word == base, "R7", old_word, base);
      @(negedge clk);
      swp_valid = 0; ld_valid = 0; swp_len_en = 0; swp_cause = 16'h0042; #1;
      chk(ia == 24'h123456, "R7", ia, 24'h123456);
      base = (w2 & ~64'h0000_FFFF_C000_0000) | (64'h0042 << 32);
      chk(old_word == base, "R7", old_word, base);
      swp_cause = '0;

      // R8 wait, problem, privileged fault
      for (int s = 0; s < 4; s++) begin
         load((s[0] ? pb(14) : 64'h0) | (s[1] ? pb(15) : 64'h0));
         for (int t = 0; t < 2; t++) begin
            priv_try = t[0]; #1;
            chk({run, problem, priv_fault} == {~s[0], s[1], s[1] & t[0]}, "R8",
                {run, problem, priv_fault}, {~s[0], s[1], s[1] & t[0]});
         end
         priv_try = 0;
      end

      // R9 format bit
      load(pb(12)); #1;
      chk(spec_err == 1, "R9", spec_err, 1);
      load(64'h0); #1;
      chk(spec_err == 0, "R9", spec_err, 0);

      // R11 condition code and address
      for (int c = 0; c < 4; c++) begin
         logic [23:0] a;
         a = 24'(c * 24'h35A5A5 + 24'h000001);
         load((64'(c) << 28) | 64'(a));
         #1;
         chk(cc == c[1:0] && ia == a, "R11", {cc, ia}, {c[1:0], a});
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule